// File: doc/BRIEF.md
# Stalling Multi-Width FIFO Access Port

This block connects a processor-style request port to two byte-wide queues that serve a scan engine. One queue carries outgoing command bytes. The other collects response bytes coming back. The processor reaches the queues through four data windows. Each window moves a fixed number of bytes per transfer: one, two, three or four. A fifth window returns a status word. This word lets software poll how full the queues are before it touches them.

Requests use a valid/ready handshake. A data write is held off until the command queue can take every byte of the transfer. A data read is held off until the response queue holds every byte the window asks for. Once the request is accepted, all of its bytes move in that single cycle, lowest lane first. An access at an offset that is not a defined window is accepted at once and has no effect on the queues. It raises an error flag that stays set until reset. On the scan side, one byte per cycle can leave the command queue and one byte per cycle can enter the response queue, at the same time as processor transfers.

Top module: `mwp_access_port`

## Requirements
- R1: Byte offsets select the window: 0x00 moves 1 byte, 0x04 moves 2, 0x08 moves 3, 0x0C moves 4, and 0x10 is the status word.
- R2: A data write pushes byte lanes in little-endian order: `req_wdata[7:0]` enters the command queue first, then `[15:8]`, and so on up to the window width. Upper lanes are dropped.
- R3: A data write keeps `req_ready` low while the command queue has fewer free entries than the window width. A stalled write pushes nothing until it is accepted, and then it pushes all of its bytes in that cycle.
- R4: A data read keeps `req_ready` low while the response queue holds fewer bytes than the window width.
- R5: An accepted read raises `rd_valid` for exactly the next cycle. In that cycle `rd_data` lane 0 is the oldest popped byte, and lanes beyond the window width are zero. `rd_data` holds its value until the next accepted read.
- R6: The status word has the response-queue occupancy in bits [5:0] and the command-queue free count in bits [21:16]. All other bits are zero. A status access never stalls, and a status write changes nothing.
- R7: Each queue is 32 entries deep. `cmd_valid` is high whenever the command queue is not empty, with the head byte on `cmd_data`. `res_ready` is high while the response queue holds fewer than 32 bytes.
- R8: An offset that is not a multiple of 4, or that is above 0x10, is accepted without stall and leaves both queues unchanged. It sets `err_flag`, which stays high until reset. A read at such an offset returns zero data.
- R9: After reset both queues are empty, the free count is 32, and `err_flag`, `rd_valid` and `rd_data` are zero. Reset asserts asynchronously and releases on the clock.
- R10: Scan-side pops and pushes in the same cycle as a processor transfer are both honoured, and the counts stay exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the window |
| req_wdata | input | 32 | Write data, lane 0 in bits [7:0] |
| req_ready | output | 1 | Request accepted this cycle when valid |
| rd_valid | output | 1 | Read data valid, one cycle after acceptance |
| rd_data | output | 32 | Read data or status word |
| err_flag | output | 1 | Sticky invalid-offset flag |
| cmd_valid | output | 1 | Command queue not empty |
| cmd_data | output | 8 | Head command byte |
| cmd_ready | input | 1 | Scan engine takes the head byte |
| res_valid | input | 1 | Scan engine offers a response byte |
| res_data | input | 8 | Response byte |
| res_ready | output | 1 | Response queue can accept a byte |

## Verification
The bench tries each window width against a queue that is empty, partly filled, exactly full and one short of the width. This tells a correct threshold apart from an off-by-one stall. Directed fills hold the scan side idle, so that a quad write meets a full queue and a quad read meets an empty one. The scan side then frees space or delivers bytes a few at a time. This separates atomic completion from partial transfers. Invalid offsets, status writes and a long mixed run with random scan-side activity separate the byte-order, masking and concurrent push/pop paths from one another.

// File: rtl/mwp_pkg.sv
package mwp_pkg;
  typedef enum logic [1:0] {
    ACC_DATA = 2'd0,
    ACC_STAT = 2'd1,
    ACC_BAD  = 2'd2
  } acc_kind_e;

  localparam int LANES    = 4;
  localparam int STAT_FREE_LSB = 16;
endpackage

// File: rtl/mwp_rst_sync.sv
module mwp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mwp_decode.sv
module mwp_decode
  import mwp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [2:0]        nbytes
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    kind   = ACC_BAD;
    nbytes = 3'd0;
    if (addr[1:0] == 2'b00) begin
      if (word < WORD_W'(LANES)) begin
        kind   = ACC_DATA;
        nbytes = 3'(word[1:0]) + 3'd1;
      end else if (word == WORD_W'(LANES)) begin
        kind = ACC_STAT;
      end
    end
  end
endmodule

// File: rtl/mwp_fifo.sv
module mwp_fifo #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int IN_L  = 1,
  parameter int OUT_L = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     in_cnt,
  input  logic [IN_L*8-1:0] in_data,
  input  logic [CW-1:0]     out_cnt,
  output logic [OUT_L*8-1:0] out_data,
  output logic [CW-1:0]     count
);
  localparam int PW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] count_q, count_d;
  logic          ptr_en;

  always_comb begin
    ptr_en  = (in_cnt != '0) || (out_cnt != '0);
    wp_d    = wp_q + PW'(in_cnt);
    rp_d    = rp_q + PW'(out_cnt);
    count_d = count_q + in_cnt - out_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_q <= '0;
    end else if (ptr_en) begin
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < IN_L; i++) begin
      if (CW'(i) < in_cnt) mem[wp_q + PW'(i)] <= in_data[i*8 +: 8];
    end
  end

  for (genvar o = 0; o < OUT_L; o++) begin : g_peek
    assign out_data[o*8 +: 8] = mem[rp_q + PW'(o)];
  end

  assign count = count_q;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt != '0) |-> (in_cnt <= CW'(DEPTH) - count_q));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt != '0) |-> (out_cnt <= count_q));
  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt == '0 && out_cnt == '0) |=> $stable(count_q));
endmodule

// File: rtl/mwp_access_port.sv
module mwp_access_port
  import mwp_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              err_flag,
  output logic              cmd_valid,
  output logic [7:0]        cmd_data,
  input  logic              cmd_ready,
  input  logic              res_valid,
  input  logic [7:0]        res_data,
  output logic              res_ready
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int DW = LANES * 8;

  logic          srst_n;
  acc_kind_e     kind;
  logic [2:0]    nb;
  logic [CW-1:0] nb_w;
  logic [CW-1:0] cmd_count, res_count, cmd_free;
  logic [CW-1:0] cmd_in_cnt, cmd_out_cnt, res_in_cnt, res_out_cnt;
  logic [7:0]    cmd_head;
  logic [DW-1:0] res_peek, lane_data, stat_word;
  logic          fire, rd_fire;
  logic          rd_valid_q, rd_valid_d;
  logic [DW-1:0] rd_data_q, rd_data_d;
  logic          err_q, err_d;

  mwp_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n)
  );

  mwp_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr(req_addr), .kind(kind), .nbytes(nb)
  );

  mwp_fifo #(.DEPTH(DEPTH), .CW(CW), .IN_L(LANES), .OUT_L(1)) i_cmd_fifo (
    .clk(clk), .rst_n(srst_n),
    .in_cnt(cmd_in_cnt), .in_data(req_wdata),
    .out_cnt(cmd_out_cnt), .out_data(cmd_head), .count(cmd_count)
  );

  mwp_fifo #(.DEPTH(DEPTH), .CW(CW), .IN_L(1), .OUT_L(LANES)) i_res_fifo (
    .clk(clk), .rst_n(srst_n),
    .in_cnt(res_in_cnt), .in_data(res_data),
    .out_cnt(res_out_cnt), .out_data(res_peek), .count(res_count)
  );

  assign nb_w     = CW'(nb);
  assign cmd_free = CW'(DEPTH) - cmd_count;

  always_comb begin
    case (kind)
      ACC_DATA: req_ready = req_write ? (cmd_free >= nb_w) : (res_count >= nb_w);
      default:  req_ready = 1'b1;
    endcase
  end

  assign fire    = req_valid && req_ready;
  assign rd_fire = fire && !req_write;

  assign cmd_valid   = (cmd_count != '0);
  assign cmd_data    = cmd_head;
  assign cmd_out_cnt = CW'(cmd_valid && cmd_ready);
  assign cmd_in_cnt  = (fire && req_write && kind == ACC_DATA) ? nb_w : '0;

  assign res_ready   = (res_count != CW'(DEPTH));
  assign res_in_cnt  = CW'(res_valid && res_ready);
  assign res_out_cnt = (rd_fire && kind == ACC_DATA) ? nb_w : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_data[l*8 +: 8] = (3'(l) < nb) ? res_peek[l*8 +: 8] : 8'h00;
  end

  always_comb begin
    stat_word = '0;
    stat_word[CW-1:0] = res_count;
    stat_word[STAT_FREE_LSB +: CW] = cmd_free;
  end

  always_comb begin
    rd_valid_d = rd_fire;
    case (kind)
      ACC_DATA: rd_data_d = lane_data;
      ACC_STAT: rd_data_d = stat_word;
      default:  rd_data_d = '0;
    endcase
    err_d = err_q || (fire && kind == ACC_BAD);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      err_q      <= 1'b0;
    end else begin
      rd_valid_q <= rd_valid_d;
      err_q      <= err_d;
      if (rd_fire) rd_data_q <= rd_data_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign err_flag = err_q;

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!srst_n)
    err_q |=> err_q);
  p_stat_nostall_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && kind == ACC_STAT) |-> req_ready);
  p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!srst_n)
    rd_fire |=> rd_valid);
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_fire |=> $stable(rd_data));
endmodule

// File: tb/test_mwp_access_port.sv
module test_mwp_access_port;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [4:0]  req_addr;
  logic [31:0] req_wdata;
  logic        req_ready, rd_valid, err_flag;
  logic [31:0] rd_data;
  logic        cmd_valid, cmd_ready, res_valid, res_ready;
  logic [7:0]  cmd_data, res_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] cmd_q[$];
  logic [7:0] rsp_q[$];
  bit         m_err, m_rdv;
  logic [31:0] m_rdata;
  logic [7:0] res_ctr;
  int pop_mode, push_mode;

  always #2.5 clk = ~clk;

  mwp_access_port i_mwp_access_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .err_flag(err_flag),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int width_of(logic [4:0] a);
    if (a[1:0] != 2'b00) return -1;
    if (a[4:2] < 3'd4) return int'(a[4:2]) + 1;
    if (a[4:2] == 3'd4) return 0;
    return -1;
  endfunction

  function automatic bit exp_ready();
    int w = width_of(req_addr);
    if (w <= 0) return 1'b1;
    if (req_write) return (DEPTH - cmd_q.size()) >= w;
    return rsp_q.size() >= w;
  endfunction

  task automatic step();
    int w;
    bit rdy, pop, push;
    logic [31:0] stat, rd;
    cmd_ready = (pop_mode == 1) ? 1'b1 : (pop_mode == 2) ? 1'($urandom) : 1'b0;
    res_valid = (push_mode == 1) ? 1'b1 : (push_mode == 2) ? 1'($urandom) : 1'b0;
    res_data  = res_ctr;
    #1;
    rdy = exp_ready();
    chk(req_write ? "R3" : "R4", "req_ready", 32'(req_ready), 32'(rdy));
    chk("R7", "cmd_valid", 32'(cmd_valid), 32'(cmd_q.size() != 0));
    if (cmd_q.size() != 0) chk("R2", "cmd_data", 32'(cmd_data), 32'(cmd_q[0]));
    chk("R7", "res_ready", 32'(res_ready), 32'(rsp_q.size() < DEPTH));
    chk("R5", "rd_valid", 32'(rd_valid), 32'(m_rdv));
    chk("R5", "rd_data", rd_data, m_rdata);
    chk("R8", "err_flag", 32'(err_flag), 32'(m_err));
    @(posedge clk);
    w    = width_of(req_addr);
    pop  = cmd_ready && (cmd_q.size() != 0);
    push = res_valid && (rsp_q.size() < DEPTH);
    stat = 32'(rsp_q.size()) | (32'(DEPTH - cmd_q.size()) << 16);
    if (pop) void'(cmd_q.pop_front());
    m_rdv = req_valid && rdy && !req_write;
    if (req_valid && rdy) begin
      if (w < 0) m_err = 1'b1;
      if (req_write && w > 0)
        for (int i = 0; i < w; i++) cmd_q.push_back(req_wdata[i*8 +: 8]);
      if (!req_write) begin
        rd = '0;
        if (w == 0) rd = stat;
        if (w > 0) for (int i = 0; i < w; i++) rd[i*8 +: 8] = rsp_q.pop_front();
        m_rdata = rd;
      end
    end
    if (push) begin
      rsp_q.push_back(res_ctr);
      res_ctr = res_ctr + 8'd37;
    end
    @(negedge clk);
  endtask

  task automatic access(bit wr, logic [4:0] a, logic [31:0] d);
    int n = 0;
    bit r;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do begin
      r = exp_ready();
      step();
      n++;
    end while (!r && n < 400);
    if (!r) begin errors++; $display("FAIL R3/R4 stall never released"); end
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    cmd_ready = 1'b0; res_valid = 1'b0; res_data = '0;
    pop_mode = 0; push_mode = 0; res_ctr = 8'h11;
    m_err = 0; m_rdv = 0; m_rdata = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "cmd_valid in reset", 32'(cmd_valid), 32'h0);
    chk("R9", "err_flag in reset", 32'(err_flag), 32'h0);
    chk("R9", "rd_valid in reset", 32'(rd_valid), 32'h0);
    chk("R9", "rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle(2);
    // R9 free count 32 via status, R6 layout
    access(0, 5'h10, 0); idle(1);
    chk("R9", "status after reset", rd_data, 32'h0020_0000);
    // R1 R2 each width, scan side idle
    access(1, 5'h00, 32'hDEAD_BEA1);
    access(1, 5'h04, 32'hDEAD_B2B1);
    access(1, 5'h08, 32'hDEC3_C2C1);
    access(1, 5'h0C, 32'hD4D3_D2D1);
    access(0, 5'h10, 0); idle(1);
    chk("R6", "status after 10 bytes", rd_data, 32'h0016_0000);
    pop_mode = 1; idle(12); pop_mode = 0;
    // R4 read stall from empty, delivered slowly
    push_mode = 2;
    access(0, 5'h0C, 0); idle(1);
    access(0, 5'h08, 0); access(0, 5'h04, 0); access(0, 5'h00, 0);
    push_mode = 0; idle(2);
    // R3 fill command queue, then stall a quad write
    for (int i = 0; i < 8; i++) access(1, 5'h0C, 32'h0101_0101 * (i + 1));
    access(0, 5'h10, 0); idle(1);
    chk("R3", "command queue full", rd_data[21:16], 32'h0);
    pop_mode = 2;
    access(1, 5'h0C, 32'hA4A3_A2A1);
    access(1, 5'h08, 32'h00B3_B2B1);
    pop_mode = 1; idle(40); pop_mode = 0;
    // R7 fill response queue to 32
    push_mode = 1; idle(36); push_mode = 0;
    access(0, 5'h10, 0); idle(1);
    chk("R7", "response full count", rd_data, 32'h0020_0020);
    access(0, 5'h08, 0); access(0, 5'h04, 0);
    // R8 invalid offsets and R6 status write ignored
    access(1, 5'h10, 32'hFFFF_FFFF);
    access(0, 5'h10, 0); idle(1);
    chk("R6", "status unchanged by write", rd_data, 32'h0020_001B);
    access(1, 5'h02, 32'h1234_5678);
    access(0, 5'h14, 0); idle(1);
    chk("R8", "bad read returns zero", rd_data, 32'h0);
    access(0, 5'h05, 0);
    access(1, 5'h1C, 32'hCAFE_F00D);
    access(0, 5'h10, 0); idle(1);
    chk("R8", "queues untouched by bad offsets", rd_data, 32'h0020_001B);
    chk("R8", "err_flag sticky", 32'(err_flag), 32'h1);
    // R10 mixed traffic with concurrent scan activity
    pop_mode = 2; push_mode = 2;
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a = 5'(($urandom % 5) * 4);
      access(1'($urandom), a, $urandom);
      if ($urandom % 4 == 0) idle(1);
    end
    idle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule